// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the serial slave at the edge of a byte-wide non-volatile memory. It accepts SPI traffic in mode 0 or mode 3. It samples the serial input on rising serial-clock edges and drives the serial output after falling edges, most significant bit first. It assembles the one-byte command and the two-byte address, and it recognises six commands. It also supports a pause input that suspends a transfer without ending it.

Read data is streamed from a synchronous byte-wide read port, and the address advances on each byte. Status reads are served from a status byte that a neighbouring block supplies. Write-enable, write-disable, status-write and array-write traffic is passed on to the neighbouring status and page-write blocks as one-cycle strobes. These strobes carry the command kind, the received address and each received data byte. A transfer-end strobe is also given, together with a count of the serial clocks seen, so that those blocks can check that chip select rose on a byte boundary.

All serial pins are brought into the system clock domain through two-flop synchronisers, and every edge is detected in that domain. The serial clock must therefore run slower than the system clock by a comfortable margin. The bench uses 16 system clocks per serial bit.

Top module: `spi_mem_front`

## Requirements
- R1: The input bit is captured on a rising serial-clock edge, MSB first. The output enable `q_oe` stays low until the first falling edge after the last command or address bit, and the output then changes only after falling edges. This applies to mode 0 (clock idle low) and to mode 3 (clock idle high at selection).
- R2: After reset, the block is selected only by a falling edge of `csn`. If `csn` is already low at reset, it starts no transaction and produces no strobes and no output.
- R3: Command bytes are decoded as 0x06 write-enable, 0x04 write-disable, 0x05 status-read, 0x01 status-write, 0x03 array-read and 0x02 array-write. An accepted command pulses `op_valid` for one cycle with `op_kind` set to 1, 2, 3, 4, 5 or 6 respectively.
- R4: An array read takes a 16-bit address, and its top bit is ignored. The read then streams the byte at that address followed by the bytes at the following addresses for as long as `csn` stays low. `addr_out` reports all 16 received bits.
- R5: The read address wraps from 0x7FFF to 0x0000.
- R6: An array read issued while `wip` is high is ignored. It gives no `op_valid`, no output and no read strobe.
- R7: A status read returns `status_byte` and repeats it for as long as `csn` stays low. It is accepted while `wip` is high.
- R8: Any other command byte makes the block ignore the rest of the transfer. No strobe is produced and the output is not enabled until `csn` rises.
- R9: After an array-write command and its address, each completed byte pulses `data_valid` with that byte. After a status-write command, the byte that follows is delivered the same way. `addr_valid` pulses once with the write address.
- R10: The pause is entered when `hold_n` falls while the serial clock is low, and it is left when `hold_n` rises while the clock is low. During the pause `q_oe` is low, and clock and data edges are ignored: they neither count nor shift.
- R11: If `hold_n` falls while the serial clock is high, the pause begins at the next falling clock edge. Until then `q_oe` stays high.
- R12: While deselected, `q_oe` and `miso` are low. A rising `csn` discards a partial command and clears a pause in progress, so the next selection starts clean.
- R13: `bit_count` counts the rising clock edges seen during the transfer. When `csn` rises, `xfer_end` pulses once with the final count held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock pin |
| csn | input | 1 | Chip select pin, active low |
| hold_n | input | 1 | Pause pin, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, low when not enabled |
| q_oe | output | 1 | Output enable for the serial data out pin |
| wip | input | 1 | Write cycle in progress, from the page-write block |
| status_byte | input | 8 | Status byte returned by a status read |
| mem_rd_en | output | 1 | Read strobe to the array |
| mem_rd_addr | output | 15 | Array read address |
| mem_rd_data | input | 8 | Array read data, one cycle after the strobe |
| op_valid | output | 1 | Accepted command strobe |
| op_kind | output | 3 | Command kind code (see R3) |
| addr_valid | output | 1 | Address received strobe |
| addr_out | output | 16 | Received address |
| data_valid | output | 1 | Write data byte strobe |
| data_byte | output | 8 | Received write data byte |
| xfer_end | output | 1 | Transfer ended by chip select rising |
| bit_count | output | 16 | Rising clocks counted in the transfer |

## Verification
A wrong command state appears at the ports within one serial byte. It shows as a missing or extra `op_valid`, as an output enabled where it should stay quiet, or as the wrong byte on the first eight output bits. A broken address counter is revealed by the byte after a page or array wrap, which the bench predicts from an address-derived data pattern. A wrong pause or selection state shows within a few system clocks of the pin edge as a wrong `q_oe` level, or at the end of the transfer as a wrong `bit_count`.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

    localparam logic [7:0] CMD_WEN  = 8'h06;
    localparam logic [7:0] CMD_WDIS = 8'h04;
    localparam logic [7:0] CMD_SRD  = 8'h05;
    localparam logic [7:0] CMD_SWR  = 8'h01;
    localparam logic [7:0] CMD_ARD  = 8'h03;
    localparam logic [7:0] CMD_AWR  = 8'h02;

    // sync vector lanes
    localparam int LANE_SCK  = 0;
    localparam int LANE_CSN  = 1;
    localparam int LANE_HOLD = 2;
    localparam int LANE_DIN  = 3;
    localparam int LANES     = 4;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_WEN   = 3'd1,
        K_WDIS  = 3'd2,
        K_SRD   = 3'd3,
        K_SWR   = 3'd4,
        K_ARD   = 3'd5,
        K_AWR   = 3'd6
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RSTREAM,
        ST_STAT,
        ST_WBYTES,
        ST_DONE,
        ST_SKIP
    } fe_state_t;

    typedef struct packed {
        logic [LANES-1:0] lvl;
        logic [LANES-1:0] rise;
        logic [LANES-1:0] fall;
    } pin_view_t;

    function automatic op_kind_t decode_cmd(input logic [7:0] b);
        case (b)
            CMD_WEN:  return K_WEN;
            CMD_WDIS: return K_WDIS;
            CMD_SRD:  return K_SRD;
            CMD_SWR:  return K_SWR;
            CMD_ARD:  return K_ARD;
            CMD_AWR:  return K_AWR;
            default:  return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_front_pkg::*;
#(
    parameter logic [LANES-1:0] RST_VAL = 4'b0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] pins,
    output pin_view_t        view
);
    logic [LANES-1:0] st1, st2, st3;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    st1[i] <= RST_VAL[i];
                    st2[i] <= RST_VAL[i];
                    st3[i] <= RST_VAL[i];
                end else begin
                    st1[i] <= pins[i];
                    st2[i] <= st1[i];
                    st3[i] <= st2[i];
                end
            end
            assign view.lvl[i]  = st2[i];
            assign view.rise[i] = st2[i] & ~st3[i];
            assign view.fall[i] = ~st2[i] & st3[i];
        end
    endgenerate
endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic selected,
    input  logic sck_lvl,
    input  logic sck_fall,
    input  logic hold_lvl,
    input  logic hold_rise,
    input  logic hold_fall,
    output logic hold_act
);
    logic enter_now, leave_now;

    assign enter_now = (hold_fall & ~sck_lvl) | (sck_fall & ~hold_lvl);
    assign leave_now = (hold_rise & ~sck_lvl) | (sck_fall & hold_lvl);

    always_ff @(posedge clk) begin
        if (rst || !selected)
            hold_act <= 1'b0;
        else if (!hold_act && enter_now)
            hold_act <= 1'b1;
        else if (hold_act && leave_now)
            hold_act <= 1'b0;
    end
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_front_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int CMD_ADDR_W = 16,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  csn_rise,
    input  logic                  csn_fall,
    input  logic                  din,
    input  logic                  hold_act,
    input  logic                  wip,
    input  logic [7:0]            status_byte,
    input  logic [7:0]            mem_rd_data,
    output logic                  selected,
    output logic                  miso,
    output logic                  q_oe,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    output logic                  op_valid,
    output op_kind_t              op_kind,
    output logic                  addr_valid,
    output logic [CMD_ADDR_W-1:0] addr_out,
    output logic                  data_valid,
    output logic [7:0]            data_byte,
    output logic                  xfer_end,
    output logic [CNT_W-1:0]      bit_count
);
    localparam int ABYTES = CMD_ADDR_W / 8;
    localparam int AB_W   = (ABYTES > 1) ? $clog2(ABYTES) : 1;

    fe_state_t             state_q;
    logic [2:0]            bitpos;
    logic [6:0]            shreg;
    logic [CMD_ADDR_W-1:0] addr_sh;
    logic [AB_W-1:0]       abyte;
    logic [2:0]            outpos;
    logic [6:0]            out_sh;
    logic                  miso_q, oe_flag, rd_pend;
    logic [7:0]            rd_buf;

    logic                  sr, fl, last_bit;
    logic [7:0]            in_byte, out_load;
    logic [CMD_ADDR_W-1:0] addr_next;
    op_kind_t              dec;

    assign selected  = (state_q != ST_IDLE);
    assign sr        = sck_rise & selected & ~hold_act;
    assign fl        = sck_fall & selected & ~hold_act;
    assign last_bit  = (bitpos == 3'd7);
    assign in_byte   = {shreg, din};
    assign addr_next = {addr_sh[CMD_ADDR_W-2:0], din};
    assign dec       = decode_cmd(in_byte);
    assign out_load  = (state_q == ST_STAT) ? status_byte : rd_buf;
    assign q_oe      = oe_flag & ~hold_act & selected;
    assign miso      = q_oe & miso_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            bitpos      <= '0;
            shreg       <= '0;
            addr_sh     <= '0;
            abyte       <= '0;
            outpos      <= '0;
            out_sh      <= '0;
            miso_q      <= 1'b0;
            oe_flag     <= 1'b0;
            rd_pend     <= 1'b0;
            rd_buf      <= '0;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
            op_valid    <= 1'b0;
            op_kind     <= K_NONE;
            addr_valid  <= 1'b0;
            addr_out    <= '0;
            data_valid  <= 1'b0;
            data_byte   <= '0;
            xfer_end    <= 1'b0;
            bit_count   <= '0;
        end else begin
            op_valid   <= 1'b0;
            addr_valid <= 1'b0;
            data_valid <= 1'b0;
            xfer_end   <= 1'b0;
            mem_rd_en  <= 1'b0;
            rd_pend    <= mem_rd_en;
            if (rd_pend)
                rd_buf <= mem_rd_data;

            if (csn_rise) begin
                xfer_end <= selected;
                state_q  <= ST_IDLE;
                oe_flag  <= 1'b0;
                miso_q   <= 1'b0;
            end else if (csn_fall && !selected) begin
                state_q   <= ST_CMD;
                bitpos    <= '0;
                bit_count <= '0;
                abyte     <= '0;
                outpos    <= '0;
                oe_flag   <= 1'b0;
                miso_q    <= 1'b0;
            end else begin
                if (sr) begin
                    bit_count <= bit_count + CNT_W'(1);
                    bitpos    <= bitpos + 3'd1;
                    shreg     <= in_byte[6:0];
                    case (state_q)
                        ST_CMD: if (last_bit) begin
                            op_kind <= dec;
                            abyte   <= '0;
                            outpos  <= '0;
                            case (dec)
                                K_WEN, K_WDIS: begin
                                    op_valid <= 1'b1;
                                    state_q  <= ST_DONE;
                                end
                                K_SRD: begin
                                    op_valid <= 1'b1;
                                    state_q  <= ST_STAT;
                                end
                                K_SWR: begin
                                    op_valid <= 1'b1;
                                    state_q  <= ST_WBYTES;
                                end
                                K_ARD: begin
                                    op_valid <= ~wip;
                                    state_q  <= wip ? ST_SKIP : ST_ADDR;
                                end
                                K_AWR: begin
                                    op_valid <= 1'b1;
                                    state_q  <= ST_ADDR;
                                end
                                default: state_q <= ST_SKIP;
                            endcase
                        end
                        ST_ADDR: begin
                            addr_sh <= addr_next;
                            if (last_bit) begin
                                abyte <= abyte + AB_W'(1);
                                if (abyte == AB_W'(ABYTES - 1)) begin
                                    addr_valid <= 1'b1;
                                    addr_out   <= addr_next;
                                    if (op_kind == K_ARD) begin
                                        mem_rd_en   <= 1'b1;
                                        mem_rd_addr <= addr_next[ADDR_W-1:0];
                                        state_q     <= ST_RSTREAM;
                                    end else begin
                                        state_q <= ST_WBYTES;
                                    end
                                end
                            end
                        end
                        ST_WBYTES: if (last_bit) begin
                            data_valid <= 1'b1;
                            data_byte  <= in_byte;
                        end
                        default: ;
                    endcase
                end

                if (fl && (state_q == ST_RSTREAM || state_q == ST_STAT)) begin
                    oe_flag <= 1'b1;
                    outpos  <= outpos + 3'd1;
                    if (outpos == 3'd0) begin
                        miso_q <= out_load[7];
                        out_sh <= out_load[6:0];
                        if (state_q == ST_RSTREAM) begin
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= mem_rd_addr + ADDR_W'(1);
                        end
                    end else begin
                        miso_q <= out_sh[6];
                        out_sh <= {out_sh[5:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spi_front_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int CMD_ADDR_W = 16,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sck,
    input  logic                  csn,
    input  logic                  hold_n,
    input  logic                  mosi,
    output logic                  miso,
    output logic                  q_oe,
    input  logic                  wip,
    input  logic [7:0]            status_byte,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic [7:0]            mem_rd_data,
    output logic                  op_valid,
    output logic [2:0]            op_kind,
    output logic                  addr_valid,
    output logic [CMD_ADDR_W-1:0] addr_out,
    output logic                  data_valid,
    output logic [7:0]            data_byte,
    output logic                  xfer_end,
    output logic [CNT_W-1:0]      bit_count
);
    pin_view_t  pv;
    logic [LANES-1:0] pins;
    logic       sck_lvl, sck_rise, sck_fall;
    logic       csn_rise, csn_fall;
    logic       hold_act, selected;
    op_kind_t   kind;
    logic       unused_edges;

    assign pins[LANE_SCK]  = sck;
    assign pins[LANE_CSN]  = csn;
    assign pins[LANE_HOLD] = hold_n;
    assign pins[LANE_DIN]  = mosi;

    // chip select resets low so a select already low at reset gives no edge
    spi_pin_sync #(.RST_VAL(4'b0100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .view (pv)
    );

    assign sck_lvl  = pv.lvl[LANE_SCK];
    assign sck_rise = pv.rise[LANE_SCK];
    assign sck_fall = pv.fall[LANE_SCK];
    assign csn_rise = pv.rise[LANE_CSN];
    assign csn_fall = pv.fall[LANE_CSN];
    assign unused_edges = ^{pv.lvl[LANE_CSN], pv.rise[LANE_DIN], pv.fall[LANE_DIN]};

    spi_hold_ctl u_hold (
        .clk       (clk),
        .rst       (rst),
        .selected  (selected),
        .sck_lvl   (sck_lvl),
        .sck_fall  (sck_fall),
        .hold_lvl  (pv.lvl[LANE_HOLD]),
        .hold_rise (pv.rise[LANE_HOLD]),
        .hold_fall (pv.fall[LANE_HOLD]),
        .hold_act  (hold_act)
    );

    spi_cmd_fsm #(
        .ADDR_W     (ADDR_W),
        .CMD_ADDR_W (CMD_ADDR_W),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .csn_rise    (csn_rise),
        .csn_fall    (csn_fall),
        .din         (pv.lvl[LANE_DIN]),
        .hold_act    (hold_act),
        .wip         (wip),
        .status_byte (status_byte),
        .mem_rd_data (mem_rd_data),
        .selected    (selected),
        .miso        (miso),
        .q_oe        (q_oe),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .op_valid    (op_valid),
        .op_kind     (kind),
        .addr_valid  (addr_valid),
        .addr_out    (addr_out),
        .data_valid  (data_valid),
        .data_byte   (data_byte),
        .xfer_end    (xfer_end),
        .bit_count   (bit_count)
    );

    assign op_kind = kind;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             selected,
    input logic             hold_act,
    input logic             sck_lvl,
    input logic             csn_fall,
    input logic             csn_rise,
    input logic             wip,
    input logic             op_valid,
    input logic [2:0]       op_kind,
    input logic             addr_valid,
    input logic             data_valid,
    input logic             xfer_end,
    input logic [CNT_W-1:0] bit_count
);
    // R2: selection only follows a synchronised falling chip select
    assert_arm_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(selected) |-> $past(csn_fall));

    // R6: an accepted array read never coincides with a busy write cycle
    assert_read_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd5) |-> !$past(wip));

    // R9: handoff strobes are mutually exclusive
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_valid, addr_valid, data_valid}));

    // R10: pause entry happens with the serial clock low
    assert_hold_clk_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_act) |-> !$past(sck_lvl));

    // R10: no clock is counted while paused
    assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (hold_act && $past(hold_act)) |-> $stable(bit_count));

    // R13: the counter moves by one at a time inside a transfer
    assert_count_step_R13: assert property (@(posedge clk) disable iff (rst)
        (selected && $past(selected) && bit_count != $past(bit_count))
            |-> bit_count == $past(bit_count) + CNT_W'(1));

    // R13: end strobe follows a chip select rise
    assert_end_after_rise_R13: assert property (@(posedge clk) disable iff (rst)
        xfer_end |-> $past(csn_rise));
endmodule

bind spi_mem_front spi_mem_front_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .selected   (selected),
    .hold_act   (hold_act),
    .sck_lvl    (sck_lvl),
    .csn_fall   (csn_fall),
    .csn_rise   (csn_rise),
    .wip        (wip),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .addr_valid (addr_valid),
    .data_valid (data_valid),
    .xfer_end   (xfer_end),
    .bit_count  (bit_count)
);

// File: tb/sim_spi_mem_front.sv
`timescale 1ns/1ps
module sim_spi_mem_front;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst, sck, csn, hold_n, mosi, wip;
    logic [7:0]  status_byte, mem_rd_data;
    logic        miso, q_oe, mem_rd_en, op_valid, addr_valid, data_valid, xfer_end;
    logic [14:0] mem_rd_addr;
    logic [2:0]  op_kind;
    logic [15:0] addr_out, bit_count;
    logic [7:0]  data_byte;

    int n_chk = 0, n_fail = 0, hi_cnt = 0;
    int opq[$], addrq[$], dataq[$], endq[$];
    logic [7:0] rx_byte;
    int oe_bits;
    bit done = 0;

    always #2 clk = ~clk;

    spi_mem_front u0 (
        .clk(clk), .rst(rst), .sck(sck), .csn(csn), .hold_n(hold_n), .mosi(mosi),
        .miso(miso), .q_oe(q_oe), .wip(wip), .status_byte(status_byte),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .op_valid(op_valid), .op_kind(op_kind), .addr_valid(addr_valid),
        .addr_out(addr_out), .data_valid(data_valid), .data_byte(data_byte),
        .xfer_end(xfer_end), .bit_count(bit_count)
    );

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // event capture and per-clock quiet-output model
    always @(negedge clk) begin
        if (!rst) begin
            if (op_valid)   opq.push_back(int'(op_kind));
            if (addr_valid) addrq.push_back(int'(addr_out));
            if (data_valid) dataq.push_back(int'(data_byte));
            if (xfer_end)   endq.push_back(int'(bit_count));
            hi_cnt = csn ? hi_cnt + 1 : 0;
            if (hi_cnt > 5) chk("R12 oe while deselected", int'(q_oe), 0);
            if (!q_oe) chk("R12 miso quiet", int'(miso), 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        opq.delete(); addrq.delete(); dataq.delete(); endq.delete();
    endtask

    task automatic xbits(input logic [7:0] tx, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            tick(HP);
            rx_byte[i] = miso;
            if (q_oe) oe_bits++;
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx);
        oe_bits = 0;
        rx_byte = '0;
        xbits(tx, 8);
    endtask

    task automatic cs_lo();
        csn = 1'b0;
        tick(6);
    endtask

    task automatic cs_hi();
        tick(HP);
        csn = 1'b1;
        tick(10);
    endtask

    task automatic qv(input string req, ref int q[$], input int idx, input int exp);
        chk(req, (q.size() > idx) ? q[idx] : -1, exp);
    endtask

    task automatic do_read(input logic [15:0] a);
        cs_lo();
        xfer(8'h03);
        xfer(a[15:8]);
        xfer(a[7:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; sck = 0; csn = 0; hold_n = 1; mosi = 0; wip = 0;
        status_byte = 8'h8C; mem_rd_data = '0;
        tick(6);
        chk("R12 reset oe", int'(q_oe), 0);
        chk("R12 reset miso", int'(miso), 0);
        chk("R13 reset count", int'(bit_count), 0);
        rst = 0;
        tick(4);

        // R2: select low through reset starts nothing
        clr();
        xfer(8'h05); xfer(8'h00);
        chk("R2 no output", oe_bits, 0);
        chk("R2 no command", opq.size(), 0);
        cs_hi();
        chk("R2 no end strobe", endq.size(), 0);

        // R7 status read repeats
        clr();
        cs_lo(); xfer(8'h05);
        xfer(8'h00);
        chk("R7 status first", int'(rx_byte), 'h8C);
        chk("R1 eight driven bits", oe_bits, 8);
        xfer(8'h00);
        chk("R7 status repeat", int'(rx_byte), 'h8C);
        cs_hi();
        qv("R3 status kind", opq, 0, 3);

        // R4 read with ignored top address bit
        clr();
        do_read(16'h9234);
        xfer(0); chk("R4 byte0", int'(rx_byte), int'(pat(15'h1234)));
        xfer(0); chk("R4 byte1", int'(rx_byte), int'(pat(15'h1235)));
        xfer(0); chk("R4 byte2", int'(rx_byte), int'(pat(15'h1236)));
        cs_hi();
        qv("R3 read kind", opq, 0, 5);
        qv("R4 address", addrq, 0, 'h9234);

        // R5 wrap
        clr();
        do_read(16'h7FFE);
        xfer(0); chk("R5 7FFE", int'(rx_byte), int'(pat(15'h7FFE)));
        xfer(0); chk("R5 7FFF", int'(rx_byte), int'(pat(15'h7FFF)));
        xfer(0); chk("R5 wrap 0", int'(rx_byte), int'(pat(15'h0000)));
        cs_hi();

        // R6 read refused while busy, R7 status still served
        clr();
        wip = 1;
        do_read(16'h0010);
        xfer(0);
        chk("R6 no output", oe_bits, 0);
        cs_hi();
        chk("R6 no command", opq.size(), 0);
        status_byte = 8'h8D;
        cs_lo(); xfer(8'h05); xfer(0);
        chk("R7 status while busy", int'(rx_byte), 'h8D);
        cs_hi();
        wip = 0;
        status_byte = 8'h8C;

        // R8 unknown command
        clr();
        cs_lo(); xfer(8'hAA); xfer(8'h05); xfer(8'h02);
        chk("R8 no output", oe_bits, 0);
        cs_hi();
        chk("R8 no strobes", opq.size() + addrq.size() + dataq.size(), 0);

        // R3 enable / disable
        clr();
        cs_lo(); xfer(8'h06); cs_hi();
        cs_lo(); xfer(8'h04); cs_hi();
        qv("R3 enable kind", opq, 0, 1);
        qv("R3 disable kind", opq, 1, 2);

        // R9 / R13 array write
        clr();
        cs_lo(); xfer(8'h02); xfer(8'h00); xfer(8'h40); xfer(8'h5A); xfer(8'hA5); cs_hi();
        qv("R3 write kind", opq, 0, 6);
        qv("R9 write address", addrq, 0, 'h0040);
        qv("R9 data 0", dataq, 0, 'h5A);
        qv("R9 data 1", dataq, 1, 'hA5);
        qv("R13 count 40", endq, 0, 40);

        // R9 status write
        clr();
        cs_lo(); xfer(8'h01); xfer(8'h9C); cs_hi();
        qv("R3 status write kind", opq, 0, 4);
        qv("R9 status data", dataq, 0, 'h9C);
        qv("R13 count 16", endq, 0, 16);

        // R13 off-boundary end
        clr();
        cs_lo(); xfer(8'h02); xfer(8'h00); xfer(8'h40); xfer(8'h5A); xbits(8'hFF, 3); cs_hi();
        qv("R13 count 35", endq, 0, 35);
        chk("R13 one data byte", dataq.size(), 1);

        // R12 partial command discarded
        clr();
        cs_lo(); xbits(8'h00, 4); cs_hi();
        cs_lo(); xfer(8'h05); xfer(0);
        chk("R12 clean after partial", int'(rx_byte), 'h8C);
        cs_hi();
        chk("R12 only one command", opq.size(), 1);

        // R10 pause between bytes
        clr();
        do_read(16'h0100);
        xfer(0); chk("R10 first byte", int'(rx_byte), int'(pat(15'h0100)));
        hold_n = 0; tick(6);
        chk("R10 oe off in pause", int'(q_oe), 0);
        for (int k = 0; k < 4; k++) begin
            mosi = k[0]; sck = 1; tick(HP); sck = 0; tick(HP);
        end
        hold_n = 1; tick(6);
        chk("R10 oe back", int'(q_oe), 1);
        xfer(0); chk("R10 byte after pause", int'(rx_byte), int'(pat(15'h0101)));
        cs_hi();
        qv("R10 clocks ignored", endq, 0, 40);

        // R11 pause requested with clock high, then deselect during pause
        clr();
        do_read(16'h0200);
        xfer(0);
        sck = 1; tick(HP);
        hold_n = 0; tick(6);
        chk("R11 not yet paused", int'(q_oe), 1);
        sck = 0; tick(6);
        chk("R11 paused at fall", int'(q_oe), 0);
        csn = 1; tick(10);
        hold_n = 1; tick(4);
        cs_lo(); xfer(8'h05); xfer(0);
        chk("R12 clean after paused deselect", int'(rx_byte), 'h8C);
        cs_hi();

        // R1 mode 3 start and first output edge
        clr();
        sck = 1; tick(HP);
        cs_lo();
        sck = 0; tick(HP);
        oe_bits = 0;
        xbits(8'h05, 7);
        mosi = 1; tick(HP); sck = 1; tick(HP);
        chk("R1 no drive before fall", int'(q_oe), 0);
        sck = 0; tick(6);
        chk("R1 drive after fall", int'(q_oe), 1);
        chk("R1 msb first", int'(miso), 1);
        tick(2);
        xfer(0);
        chk("R1 mode 3 status", int'(rx_byte), 'h8C);
        cs_hi();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule